// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block sits between a synchronous request port and a 16-bit asynchronous static RAM that has two byte lanes. A requester offers one access at a time through a valid/ready handshake: a write flag, an address, sixteen bits of write data and a two-bit lane mask. The controller turns each accepted request into a pin-level cycle. It drives a pair of chip enables of opposite polarity, an active-low output enable, an active-low write strobe, two active-low lane enables and the address. It also drives a data word with its own driver-enable. Read data comes back in a register together with a one-clock valid pulse.

Every phase length is a whole number of clocks, derived at elaboration from the clock period and the memory's nanosecond limits. Each limit is rounded up. The read window covers the address access time, the output-enable access time and the read cycle time. The write pulse covers the pulse width, the data-to-strobe-release overlap and the enable-to-end-of-write limits. A trailing phase tops the write up to the write cycle time. After a read, a float counter keeps the controller's data driver off until the memory has had time to release the bus. A write that follows a read waits out this float time in a turnaround phase.

Top module: `sram_ctl16`

## Requirements
- R1: Out of reset and whenever idle: mem_ce_n=1, mem_ce=0, mem_outen_n=1, mem_wren_n=1, mem_lo_n=1, mem_hi_n=1, mem_dout_en=0, req_ready=1, rdata_valid=0; mem_ce is always the inverse of mem_ce_n.
- R2: A read holds the chip enables, mem_outen_n low, the lane enables and the address for exactly N_RD = ceil(max(T_RC,T_AA,T_OE)/CLK_NS) clocks with mem_wren_n high, and samples mem_din at the edge that closes that window.
- R3: rdata_valid is a single-clock pulse that rises N_RD clocks after the accepting edge, with rdata holding the sampled word.
- R4: A write asserts the chip enables, the lanes and the address for one setup clock with mem_wren_n high, then drives mem_wren_n low for exactly N_WP = ceil(max(T_WP,T_DW,T_CW)/CLK_NS) clocks; mem_outen_n stays high throughout.
- R5: mem_dout_en is high exactly while mem_wren_n is low, mem_dout carries the request's write data unchanged for that whole time, and the driver is released on the edge that raises mem_wren_n.
- R6: A write keeps the chip selected for 1 + N_WP + N_END clocks, where N_END = max(1, ceil(T_WC/CLK_NS) - 1 - N_WP), so the chip-select time is never below the write cycle time.
- R7: Mask bit 0 enables the low lane (data bits 7:0, mem_lo_n low) and bit 1 enables the high lane (bits 15:8, mem_hi_n low); both bits give a word access; a write leaves the disabled lanes of the stored word unchanged, and a mask of 0 changes nothing.
- R8: After mem_outen_n rises, mem_dout_en stays low for at least N_OHZ = ceil(T_OHZ/CLK_NS) clocks; a write requested inside that window passes through a turnaround phase first.
- R9: req_ready is low from the accepting edge until the cycle ends: N_RD+1 clocks for a read, 1+N_WP+N_END clocks for a write with no turnaround.
- R10: The address and lane enables stay stable for as long as the chip is selected, and equal the accepted request's values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane mask, bit 0 low lane, bit 1 high lane |
| rdata | output | 16 | Registered read data |
| rdata_valid | output | 1 | One-clock pulse marking rdata |
| mem_ce_n | output | 1 | Active-low chip enable |
| mem_ce | output | 1 | Active-high chip enable |
| mem_outen_n | output | 1 | Active-low memory output enable |
| mem_wren_n | output | 1 | Active-low write strobe |
| mem_lo_n | output | 1 | Active-low low-lane enable |
| mem_hi_n | output | 1 | Active-low high-lane enable |
| mem_addr | output | ADDR_W | Memory address |
| mem_dout | output | 16 | Data toward the memory |
| mem_dout_en | output | 1 | Driver enable for mem_dout |
| mem_din | input | 16 | Data from the memory |

## Verification
The bench builds the block with a 5 ns clock and the 55 ns grade limits. These give N_RD=11, N_WP=9, N_END=1 and N_OHZ=4, so every phase length is small enough to count clock by clock. A behavioural memory model in the bench returns correct data only once the address and output enable have been stable long enough. It commits a write only if pulse width, data lead and select time were met, and it flags any driver overlap inside the float window. The sweep covers all four lane masks over many addresses with both address bytes varied, and it runs reads followed at once by writes to force the turnaround path.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RD_ACCESS,
        PH_RD_CAPTURE,
        PH_WR_SETUP,
        PH_WR_PULSE,
        PH_WR_END,
        PH_TURN
    } phase_e;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        return max2(max2(a, b), c);
    endfunction

endpackage

// File: rtl/sramc_phase_timer.sv
module sramc_phase_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sramc_lane_map.sv
module sramc_lane_map #(
    parameter int LANES = 2
) (
    input  logic [LANES-1:0] mask,
    output logic [LANES-1:0] lane_n
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_n[i] = ~mask[i];
    end
endmodule

// File: rtl/sram_ctl16.sv
module sram_ctl16
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CLK_NS = 5,
    parameter int T_RC   = 55,
    parameter int T_AA   = 55,
    parameter int T_OE   = 25,
    parameter int T_WC   = 55,
    parameter int T_WP   = 40,
    parameter int T_CW   = 45,
    parameter int T_DW   = 25,
    parameter int T_OHZ  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    input  logic [1:0]        req_be,
    output logic [15:0]       rdata,
    output logic              rdata_valid,
    output logic              mem_ce_n,
    output logic              mem_ce,
    output logic              mem_outen_n,
    output logic              mem_wren_n,
    output logic              mem_lo_n,
    output logic              mem_hi_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_dout,
    output logic              mem_dout_en,
    input  logic [15:0]       mem_din
);
    localparam int LANES = 2;
    localparam int DATA_W = 8 * LANES;
    localparam int N_RD  = max2(1, max3(ceil_div(T_RC, CLK_NS), ceil_div(T_AA, CLK_NS),
                                        ceil_div(T_OE, CLK_NS)));
    localparam int N_WP  = max2(1, max3(ceil_div(T_WP, CLK_NS), ceil_div(T_DW, CLK_NS),
                                        ceil_div(T_CW, CLK_NS)));
    localparam int N_WC  = ceil_div(T_WC, CLK_NS);
    localparam int N_END = max2(1, N_WC - 1 - N_WP);
    localparam int N_OHZ = max2(1, ceil_div(T_OHZ, CLK_NS));
    localparam int N_MAX = max2(max2(N_RD, N_WP), max2(N_END, N_OHZ));
    localparam int CW    = $clog2(N_MAX + 1);

    typedef struct packed {
        phase_e              ph;
        logic                ce;
        logic                outen;
        logic                wren;
        logic                drv;
        logic [LANES-1:0]    lane_n;
        logic [LANES-1:0]    lane_hold;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdat;
        logic [DATA_W-1:0]   rdat;
        logic                rvld;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             ph_load, ph_zero;
    logic [CW-1:0]    ph_val;
    logic             flt_load, flt_zero;
    logic [LANES-1:0] req_lane_n;

    sramc_lane_map #(.LANES(LANES)) u_lane_map (
        .mask   (req_be),
        .lane_n (req_lane_n)
    );

    sramc_phase_timer #(.W(CW)) u_phase_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_val),
        .zero     (ph_zero)
    );

    sramc_phase_timer #(.W(CW)) u_float_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (flt_load),
        .load_val (CW'(N_OHZ)),
        .zero     (flt_zero)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.rvld = 1'b0;
        ph_load    = 1'b0;
        ph_val     = '0;
        flt_load   = 1'b0;

        unique case (ctl_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    ctl_d.addr      = req_addr;
                    ctl_d.wdat      = req_wdata;
                    ctl_d.lane_hold = req_lane_n;
                    if (req_write) begin
                        if (flt_zero) begin
                            ctl_d.ph     = PH_WR_SETUP;
                            ctl_d.ce     = 1'b1;
                            ctl_d.lane_n = req_lane_n;
                        end else begin
                            ctl_d.ph = PH_TURN;
                        end
                    end else begin
                        ctl_d.ph     = PH_RD_ACCESS;
                        ctl_d.ce     = 1'b1;
                        ctl_d.outen  = 1'b1;
                        ctl_d.lane_n = req_lane_n;
                        ph_load      = 1'b1;
                        ph_val       = CW'(N_RD - 1);
                    end
                end
            end
            PH_RD_ACCESS: begin
                if (ph_zero) begin
                    ctl_d.ph     = PH_RD_CAPTURE;
                    ctl_d.rdat   = mem_din;
                    ctl_d.rvld   = 1'b1;
                    ctl_d.ce     = 1'b0;
                    ctl_d.outen  = 1'b0;
                    ctl_d.lane_n = '1;
                    flt_load     = 1'b1;
                end
            end
            PH_RD_CAPTURE: begin
                ctl_d.ph = PH_IDLE;
            end
            PH_TURN: begin
                if (flt_zero) begin
                    ctl_d.ph     = PH_WR_SETUP;
                    ctl_d.ce     = 1'b1;
                    ctl_d.lane_n = ctl_q.lane_hold;
                end
            end
            PH_WR_SETUP: begin
                ctl_d.ph   = PH_WR_PULSE;
                ctl_d.wren = 1'b1;
                ctl_d.drv  = 1'b1;
                ph_load    = 1'b1;
                ph_val     = CW'(N_WP - 1);
            end
            PH_WR_PULSE: begin
                if (ph_zero) begin
                    ctl_d.ph   = PH_WR_END;
                    ctl_d.wren = 1'b0;
                    ctl_d.drv  = 1'b0;
                    ph_load    = 1'b1;
                    ph_val     = CW'(N_END - 1);
                end
            end
            PH_WR_END: begin
                if (ph_zero) begin
                    ctl_d.ph     = PH_IDLE;
                    ctl_d.ce     = 1'b0;
                    ctl_d.lane_n = '1;
                end
            end
            default: begin
                ctl_d.ph = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q           <= '0;
            ctl_q.ph        <= PH_IDLE;
            ctl_q.lane_n    <= '1;
            ctl_q.lane_hold <= '1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready   = (ctl_q.ph == PH_IDLE);
    assign rdata       = ctl_q.rdat;
    assign rdata_valid = ctl_q.rvld;
    assign mem_ce_n    = ~ctl_q.ce;
    assign mem_ce      = ctl_q.ce;
    assign mem_outen_n = ~ctl_q.outen;
    assign mem_wren_n  = ~ctl_q.wren;
    assign mem_lo_n    = ctl_q.lane_n[0];
    assign mem_hi_n    = ctl_q.lane_n[1];
    assign mem_addr    = ctl_q.addr;
    assign mem_dout    = ctl_q.wdat;
    assign mem_dout_en = ctl_q.drv;
endmodule

// File: rtl/sram_ctl16_chk.sv
module sram_ctl16_chk
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CLK_NS = 5,
    parameter int T_OHZ  = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rdata_valid,
    input logic              mem_ce_n,
    input logic              mem_ce,
    input logic              mem_outen_n,
    input logic              mem_wren_n,
    input logic              mem_lo_n,
    input logic              mem_hi_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_dout_en
);
    localparam int N_OHZ = max2(1, ceil_div(T_OHZ, CLK_NS));

    logic [15:0] since_oe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_oe_q <= 16'hFFFF;
        end else if (!mem_outen_n) begin
            since_oe_q <= '0;
        end else if (since_oe_q != 16'hFFFF) begin
            since_oe_q <= since_oe_q + 1'b1;
        end
    end

    a_r1_ce_pair: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce == !mem_ce_n);

    a_r2_read_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_outen_n |-> (mem_wren_n && !mem_ce_n));

    a_r3_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |=> !rdata_valid);

    a_r4_no_outen_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wren_n |-> (mem_outen_n && !mem_ce_n));

    a_r5_driver_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dout_en == !mem_wren_n);

    a_r5_release_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wren_n) |-> !mem_dout_en);

    a_r8_float_gap: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dout_en |-> (since_oe_q >= 16'(N_OHZ)));

    a_r9_busy_when_selected: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> !req_ready);

    a_r10_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_lo_n)
                                             && $stable(mem_hi_n)));
endmodule

bind sram_ctl16 sram_ctl16_chk #(
    .ADDR_W (ADDR_W),
    .CLK_NS (CLK_NS),
    .T_OHZ  (T_OHZ)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .rdata_valid (rdata_valid),
    .mem_ce_n    (mem_ce_n),
    .mem_ce      (mem_ce),
    .mem_outen_n (mem_outen_n),
    .mem_wren_n  (mem_wren_n),
    .mem_lo_n    (mem_lo_n),
    .mem_hi_n    (mem_hi_n),
    .mem_addr    (mem_addr),
    .mem_dout_en (mem_dout_en)
);

// File: tb/sram_ctl16_tb_top.sv
module sram_ctl16_tb_top;
    localparam int CLK_NS = 5;
    localparam int N_RD   = 11;   // ceil(55/5)
    localparam int N_WP   = 9;    // ceil(45/5)
    localparam int N_END  = 1;    // max(1, 11-1-9)
    localparam int N_OHZ  = 4;    // ceil(20/5)
    localparam int M_WP   = 8;    // ceil(40/5) pulse width seen by memory
    localparam int M_DW   = 5;    // ceil(25/5) data lead
    localparam int M_CW   = 9;    // ceil(45/5) select to end of write
    localparam int M_AA   = 11;   // ceil(55/5) address access
    localparam int M_OE   = 5;    // ceil(25/5) output-enable access
    localparam int M_CYC  = 11;   // ceil(55/5) cycle time

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic [15:0] rdata;
    logic        rdata_valid;
    logic        mem_ce_n, mem_ce, mem_outen_n, mem_wren_n, mem_lo_n, mem_hi_n;
    logic [15:0] mem_addr, mem_dout;
    logic        mem_dout_en;
    logic [15:0] mem_din = '0;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    sram_ctl16 #(.ADDR_W(16), .CLK_NS(CLK_NS)) dut_i (
        .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_addr, .req_wdata,
        .req_be, .rdata, .rdata_valid, .mem_ce_n, .mem_ce, .mem_outen_n,
        .mem_wren_n, .mem_lo_n, .mem_hi_n, .mem_addr, .mem_dout, .mem_dout_en,
        .mem_din
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Behavioural memory and golden image (index = low address byte)
    logic [15:0] mem_arr [256];
    logic [15:0] gold    [256];
    logic [15:0] cur_addr = '0;
    logic [15:0] cur_wdata = '0;
    logic [1:0]  cur_be = '0;

    int  addr_age = 0, oe_age = 0, we_lo = 0, dstab = 0, cs_age = 0, oe_hi = 1000;
    bit  prev_sel = 0, prev_wl = 0, prev_drv = 0, wr_seen = 0;
    logic [15:0] prev_addr = '0, prev_dq = '0;
    logic        prev_lo = 1'b1, prev_hi = 1'b1;

    function automatic logic [15:0] lane_mask(input logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            bit sel;
            logic [15:0] v;
            sel = !mem_ce_n && mem_ce;
            if (prev_wl && mem_wren_n) begin
                chk(we_lo >= M_WP, "R4", "strobe width", we_lo, M_WP);
                chk(cs_age - 1 >= M_CW, "R4", "select to end of write", cs_age - 1, M_CW);
                chk(dstab >= M_DW, "R5", "data lead", dstab, M_DW);
                chk(prev_dq == cur_wdata, "R5", "write data", prev_dq, cur_wdata);
                chk(!mem_dout_en, "R5", "driver released with strobe", mem_dout_en, 0);
                chk({prev_hi, prev_lo} == ~cur_be, "R7", "lane enables",
                    {prev_hi, prev_lo}, ~cur_be);
                mem_arr[prev_addr[7:0]] = (mem_arr[prev_addr[7:0]] & ~lane_mask(~{prev_hi, prev_lo}))
                                        | (prev_dq & lane_mask(~{prev_hi, prev_lo}));
                wr_seen = 1;
            end
            if (prev_sel && !sel) begin
                chk(cs_age >= M_CYC, wr_seen ? "R6" : "R2", "select length", cs_age, M_CYC);
                if (wr_seen) chk(cs_age == 1 + N_WP + N_END, "R6", "write select", cs_age,
                                 1 + N_WP + N_END);
                else         chk(cs_age == N_RD, "R2", "read select", cs_age, N_RD);
                wr_seen = 0;
            end
            if (sel) chk(mem_addr == cur_addr, "R10", "address held", mem_addr, cur_addr);
            if (mem_dout_en) begin
                chk(oe_hi >= N_OHZ, "R8", "float gap before drive", oe_hi, N_OHZ);
                chk(!mem_wren_n, "R5", "driver only with strobe", mem_wren_n, 0);
            end
            addr_age = sel ? ((prev_sel && mem_addr == prev_addr) ? addr_age + 1 : 1) : 0;
            oe_age   = (sel && !mem_outen_n) ? oe_age + 1 : 0;
            oe_hi    = !mem_outen_n ? 0 : ((oe_hi < 1000) ? oe_hi + 1 : oe_hi);
            we_lo    = (sel && !mem_wren_n) ? we_lo + 1 : 0;
            dstab    = mem_dout_en ? ((prev_drv && mem_dout == prev_dq) ? dstab + 1 : 1) : 0;
            cs_age   = sel ? cs_age + 1 : 0;
            v = mem_arr[mem_addr[7:0]];
            if (sel && !mem_outen_n && mem_wren_n && oe_age >= M_OE && addr_age >= M_AA)
                mem_din = {mem_hi_n ? 8'hEE : v[15:8], mem_lo_n ? 8'hEE : v[7:0]};
            else
                mem_din = ~v;
            prev_sel = sel;  prev_wl = sel && !mem_wren_n;  prev_drv = mem_dout_en;
            prev_addr = mem_addr;  prev_dq = mem_dout;  prev_lo = mem_lo_n;  prev_hi = mem_hi_n;
        end
    end

    task automatic issue(input bit wr, input logic [15:0] a, input logic [15:0] d,
                         input logic [1:0] be);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        while (!req_ready) @(negedge clk);
        cur_addr = a; cur_wdata = d; cur_be = be;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R9", "ready after accept", req_ready, 0);
    endtask

    task automatic do_write(input logic [15:0] a, input logic [15:0] d,
                            input logic [1:0] be, input bit exact);
        int n = 0;
        issue(1'b1, a, d, be);
        gold[a[7:0]] = (gold[a[7:0]] & ~lane_mask(be)) | (d & lane_mask(be));
        while (!req_ready && n < 100) begin
            @(negedge clk); n++;
        end
        if (exact) chk(n == 1 + N_WP + N_END, "R9", "write busy length", n, 1 + N_WP + N_END);
        else       chk(n >= 1 + N_WP + N_END, "R8", "write after read busy", n, 1 + N_WP + N_END);
    endtask

    task automatic do_read(input logic [15:0] a, input logic [1:0] be);
        int n = 0;
        logic [15:0] m;
        issue(1'b0, a, 16'h0, be);
        while (!rdata_valid && n < 100) begin
            @(negedge clk); n++;
        end
        chk(n == N_RD, "R3", "read latency", n, N_RD);
        m = lane_mask(be);
        chk((rdata & m) == (gold[a[7:0]] & m), "R2", "read data", rdata & m, gold[a[7:0]] & m);
        chk(!req_ready, "R9", "busy during valid", req_ready, 0);
        @(negedge clk);
        chk(!rdata_valid, "R3", "valid is one clock", rdata_valid, 0);
        chk(req_ready, "R9", "ready after read", req_ready, 1);
    endtask

    function automatic logic [15:0] addr_of(input int i);
        return {8'((i * 29 + 3) & 255), 8'((i * 7) & 255)};
    endfunction

    initial begin : watchdog
        int cyc = 0;
        while (cyc < 200000) begin
            @(posedge clk); cyc++;
        end
        errors++; checks++;
        $display("FAIL watchdog expired: actual %0d expected below %0d", cyc, 200000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem_arr[i] = '0; gold[i] = '0;
        end
        repeat (4) @(negedge clk);
        chk(mem_ce_n && !mem_ce && mem_outen_n && mem_wren_n, "R1", "reset controls",
            {mem_ce_n, mem_ce, mem_outen_n, mem_wren_n}, 4'b1011);
        chk(mem_lo_n && mem_hi_n && !mem_dout_en, "R1", "reset lanes and driver",
            {mem_lo_n, mem_hi_n, mem_dout_en}, 3'b110);
        chk(req_ready && !rdata_valid, "R1", "reset handshake",
            {req_ready, rdata_valid}, 2'b10);
        rst_n = 1'b1;
        // full-word fill
        for (int i = 0; i < 32; i++)
            do_write(addr_of(i), 16'(i * 16'h0101) ^ 16'h5A3C, 2'b11, 1'b1);
        chk(mem_ce_n && !mem_ce && mem_outen_n && mem_lo_n && mem_hi_n, "R1", "idle after writes",
            {mem_ce_n, mem_ce, mem_outen_n, mem_lo_n, mem_hi_n}, 5'b10111);
        // lane writes with every mask, including mask 0 (R7)
        for (int i = 0; i < 32; i++)
            do_write(addr_of(i), 16'(i * 16'h1357) ^ 16'hC3A1, 2'(i % 4), 1'b1);
        // read sweep over all non-empty masks (R2, R7)
        for (int i = 0; i < 32; i++)
            for (int be = 1; be < 4; be++)
                do_read(addr_of(i), 2'(be));
        // read followed at once by write, then readback (R8)
        for (int i = 0; i < 12; i++) begin
            do_read(addr_of(i), 2'b11);
            do_write(addr_of(i), 16'(i * 16'h2F11) ^ 16'h0F0F, 2'(1 + i % 3), 1'b0);
            do_read(addr_of(i), 2'b11);
        end
        repeat (3) @(negedge clk);
        chk(req_ready && !mem_dout_en && mem_outen_n, "R1", "idle at end",
            {req_ready, mem_dout_en, mem_outen_n}, 3'b101);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule